// File: doc/BRIEF.md
# Windowed Coincidence Trigger

This block turns four single-bit discriminator signals into one trigger strobe. Each input comes from a comparator with one threshold and may change at any time. Each channel is synchronised and watched for a rising or a falling edge, chosen per channel. Every qualifying edge opens a window of programmable length. This lets two short pulses that arrive some cycles apart still overlap.

The open windows are combined in one of three ways: any enabled channel, all enabled channels, or channel pairs (0 and 1, or 2 and 3). The combined signal must stay true for longer than a programmable minimum before it counts. A counted coincidence gives a strobe one clock wide. Another strobe cannot follow until every window has closed.

Top module: `coinc_trigger`

## Requirements
- R1: An edge that is presented on `disc_in` just after clock edge C produces `trig_out` high in the cycle after clock edge C+4. This assumes mode 0, minimum width 0 and an idle block. The path is two synchroniser stages, edge detection, the window register and the strobe register.
- R2: When `edge_fall[i]` is 0, channel i reacts only to a 0-to-1 change. When it is 1, channel i reacts only to a 1-to-0 change. A change in the other direction opens no window.
- R3: A qualifying edge opens the channel's window for exactly `win_len` cycles. A new qualifying edge while the window is open reloads the full length. If the reload lands on the last open cycle, the window stays open with no gap. A `win_len` of 0 opens no window.
- R4: `mode` = 0 (OR) is true while any channel whose `chan_en` bit is 1 has an open window. A channel with `chan_en` 0 is ignored.
- R5: `mode` = 1 (AND) is true only while every enabled channel has an open window. With no channel enabled it is never true.
- R6: `mode` = 2 (pairs) is true while channels 0 and 1 are both open, or channels 2 and 3 are both open. `chan_en` has no effect in this mode. `mode` = 3 is never true.
- R7: A strobe is issued only once the combined condition has held for more than `min_width` consecutive cycles. A value of 0 accepts a one-cycle overlap.
- R8: `trig_out` is high for one cycle per coincidence. After a strobe, no further strobe occurs until there has been a cycle in which all windows were closed.
- R9: While `rst_n` is low at a clock edge, all windows close and `trig_out` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| disc_in | input | NCH (4) | Asynchronous discriminator bits |
| edge_fall | input | NCH (4) | Per channel: 1 = falling-edge sensitive, 0 = rising |
| chan_en | input | NCH (4) | Channel enable mask for OR and AND modes |
| mode | input | 2 | 0 OR, 1 AND, 2 pairs, 3 off |
| win_len | input | WIN_W (8) | Window length in cycles |
| min_width | input | MINW_W (4) | Overlap must exceed this many cycles |
| trig_out | output | 1 | One-cycle trigger strobe |

## Verification
Two events can fall on the same cycle: a window reload and the natural expiry of that window. When they coincide, the reload must win. Otherwise the window drops for one cycle, the hold-off releases and a second strobe appears. The bench provokes this in OR mode on a single channel. It sends a second pulse timed to reload the window exactly on its last open cycle and expects one strobe. It then sends the same pair of pulses one cycle later, which leaves a one-cycle gap, and expects two strobes.

// File: rtl/coinc_pkg.sv
// Shared encodings for the coincidence trigger.
// Assumes: mode is a 2-bit field decoded only by coinc_combine.
package coinc_pkg;
    typedef enum logic [1:0] {
        CM_ANY  = 2'd0,
        CM_ALL  = 2'd1,
        CM_PAIR = 2'd2,
        CM_OFF  = 2'd3
    } comb_mode_e;
endpackage

// File: rtl/coinc_chan_front.sv
// One channel front end: two-stage synchroniser, polarity-selected edge
// detect and a reloadable window counter.
// Assumes: din is asynchronous; win_len is quasi-static.
module coinc_chan_front #(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic             fall_sel,
    input  logic [WIN_W-1:0] win_len,
    output logic             act_o
);
    logic             sync1, sync2, prev;
    logic [WIN_W-1:0] cnt;
    logic             hit;

    // synchronise and keep the previous sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            prev  <= 1'b0;
        end else begin
            sync1 <= din;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    // qualifying edge in the selected direction
    always_comb hit = fall_sel ? (prev & ~sync2) : (sync2 & ~prev);

    // window counter: reload on edge, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (hit)        cnt <= win_len;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign act_o = (cnt != '0);

    // R3: an edge with a nonzero length opens the window next cycle
    a_r3_edge_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && win_len != '0) |=> act_o);
    // R3: a closed window stays closed without an edge
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !act_o) |=> !act_o);
endmodule

// File: rtl/coinc_combine.sv
// Combines the open-window flags according to the selected mode.
// Assumes: NCH is even; pairs are (0,1), (2,3), ...
module coinc_combine
    import coinc_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] act_i,
    input  logic [NCH-1:0] en_i,
    input  logic [1:0]     mode_i,
    output logic           comb_o
);
    localparam int NPAIR = NCH / 2;

    logic [NPAIR-1:0] pair_hit;
    comb_mode_e       md;

    genvar k;
    generate
        for (k = 0; k < NPAIR; k++) begin : g_pair
            assign pair_hit[k] = act_i[2*k] & act_i[2*k+1];
        end
    endgenerate

    // select the combining function
    always_comb begin
        md = comb_mode_e'(mode_i);
        case (md)
            CM_ANY:  comb_o = |(act_i & en_i);
            CM_ALL:  comb_o = (&(act_i | ~en_i)) & (|en_i);
            CM_PAIR: comb_o = |pair_hit;
            default: comb_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/coinc_qualify.sv
// Minimum-width qualification, one-cycle strobe and hold-off.
// Assumes: any_act is high whenever comb is high.
module coinc_qualify #(
    parameter int MINW_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              comb_i,
    input  logic              any_act_i,
    input  logic [MINW_W-1:0] min_width,
    output logic              trig_o
);
    localparam logic [MINW_W-1:0] RUN_MAX = '1;

    logic [MINW_W-1:0] run;
    logic              qual, fired;

    // count prior consecutive cycles of coincidence, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || !comb_i) run <= '0;
        else if (run != RUN_MAX) run <= run + 1'b1;
    end

    always_comb qual = comb_i && (run >= min_width);

    // issue the strobe and hold off until every window has closed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_o <= 1'b0;
            fired  <= 1'b0;
        end else begin
            trig_o <= qual && !fired;
            if (qual && !fired) fired <= 1'b1;
            else if (!any_act_i) fired <= 1'b0;
        end
    end

    // R8: strobe lasts exactly one cycle
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);
    // R8: no strobe while held off
    a_r8_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && any_act_i) |=> !trig_o);
    // R7: a strobe follows a cycle with coincidence present
    a_r7_needs_comb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_o) |-> $past(comb_i));
endmodule

// File: rtl/coinc_trigger.sv
// Top: four windowed channels, mode combiner and strobe qualifier.
// Assumes: inputs other than disc_in are static while windows are open.
module coinc_trigger #(
    parameter int NCH    = 4,
    parameter int WIN_W  = 8,
    parameter int MINW_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    disc_in,
    input  logic [NCH-1:0]    edge_fall,
    input  logic [NCH-1:0]    chan_en,
    input  logic [1:0]        mode,
    input  logic [WIN_W-1:0]  win_len,
    input  logic [MINW_W-1:0] min_width,
    output logic              trig_out
);
    logic [NCH-1:0] act;
    logic           comb;

    genvar i;
    generate
        for (i = 0; i < NCH; i++) begin : g_ch
            coinc_chan_front #(.WIN_W(WIN_W)) u_front (
                .clk      (clk),
                .rst_n    (rst_n),
                .din      (disc_in[i]),
                .fall_sel (edge_fall[i]),
                .win_len  (win_len),
                .act_o    (act[i])
            );
        end
    endgenerate

    coinc_combine #(.NCH(NCH)) u_comb (
        .act_i  (act),
        .en_i   (chan_en),
        .mode_i (mode),
        .comb_o (comb)
    );

    coinc_qualify #(.MINW_W(MINW_W)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .comb_i    (comb),
        .any_act_i (|act),
        .min_width (min_width),
        .trig_o    (trig_out)
    );

    // R5: AND mode with an empty mask never coincides
    a_r5_empty_and: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && chan_en == '0) |-> !comb);
    // R6: the off encoding never coincides
    a_r6_off_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> !comb);
    // R4: OR mode is true whenever an enabled window is open
    a_r4_or_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && (act & chan_en) != '0) |-> comb);
endmodule

// File: tb/tb_coinc_trigger.sv
module tb_coinc_trigger;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] disc_in = '0, edge_fall = '0, chan_en = '0;
    logic [1:0] mode = '0;
    logic [7:0] win_len = 8'd10;
    logic [3:0] min_width = '0;
    logic       trig_out;

    int cyc = 0, trig_cnt = 0, last_trig = -1;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (trig_out) begin trig_cnt++; last_trig = cyc; end

    coinc_trigger dut (.clk(clk), .rst_n(rst_n), .disc_in(disc_in),
        .edge_fall(edge_fall), .chan_en(chan_en), .mode(mode),
        .win_len(win_len), .min_width(min_width), .trig_out(trig_out));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic setup(input logic [1:0] m, input logic [3:0] en,
                         input logic [7:0] w, input logic [3:0] mw);
        @(negedge clk);
        mode = m; chan_en = en; win_len = w; min_width = mw;
        trig_cnt = 0;
    endtask

    task automatic settle();
        repeat (270) @(negedge clk);
    endtask

    // A at t, B at t+d (d >= 1)
    task automatic two_pulse(input int a, input int b, input int d);
        @(negedge clk); disc_in[a] = 1'b1;
        @(negedge clk); disc_in[a] = 1'b0;
        repeat (d - 1) @(negedge clk);
        disc_in[b] = 1'b1;
        @(negedge clk); disc_in[b] = 1'b0;
    endtask

    task automatic count_is(input int exp, input string req);
        settle();
        check(trig_cnt == exp, req, trig_cnt, exp);
        trig_cnt = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(trig_out == 1'b0, "R9 reset", int'(trig_out), 0);
        disc_in = 4'b0001; mode = 0; chan_en = 4'b1111;
        @(negedge clk); rst_n = 1'b0; disc_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        trig_cnt = 0;
        count_is(0, "R9 window cleared by reset");
    endtask

    task automatic t_latency();
        int t0;
        setup(2'd0, 4'b0001, 8'd10, 4'd0);
        @(negedge clk); disc_in[0] = 1'b1; t0 = cyc;
        @(negedge clk); disc_in[0] = 1'b0;
        settle();
        check(last_trig == t0 + 4, "R1 latency", last_trig, t0 + 4);
        check(trig_cnt == 1, "R1 single strobe", trig_cnt, 1);
    endtask

    task automatic t_or_mask();
        setup(2'd0, 4'b0001, 8'd10, 4'd0);
        two_pulse(2, 3, 2);
        count_is(0, "R4 masked channels ignored");
        setup(2'd0, 4'b0100, 8'd10, 4'd0);
        two_pulse(2, 2, 20);
        count_is(2, "R4 enabled channel fires");
    endtask

    task automatic t_and();
        setup(2'd1, 4'b0011, 8'd10, 4'd0);
        two_pulse(0, 1, 9);
        count_is(1, "R5 overlap inside window");
        two_pulse(0, 1, 10);
        count_is(0, "R5 no overlap past window");
        setup(2'd1, 4'b0111, 8'd10, 4'd0);
        two_pulse(0, 1, 3);
        count_is(0, "R5 third channel missing");
        @(negedge clk); disc_in = 4'b0111;
        @(negedge clk); disc_in = 4'b0000;
        count_is(1, "R5 all three together");
        setup(2'd1, 4'b0000, 8'd10, 4'd0);
        @(negedge clk); disc_in = 4'b1111;
        @(negedge clk); disc_in = 4'b0000;
        count_is(0, "R5 empty mask");
    endtask

    task automatic t_pair();
        setup(2'd2, 4'b0000, 8'd10, 4'd0);
        two_pulse(0, 2, 2);
        count_is(0, "R6 cross pair");
        two_pulse(2, 3, 2);
        count_is(1, "R6 pair 2&3 ignores mask");
        two_pulse(1, 0, 2);
        count_is(1, "R6 pair 0&1");
        setup(2'd3, 4'b1111, 8'd10, 4'd0);
        @(negedge clk); disc_in = 4'b1111;
        @(negedge clk); disc_in = 4'b0000;
        count_is(0, "R6 off mode");
    endtask

    task automatic t_minw();
        setup(2'd1, 4'b0011, 8'd10, 4'd5);
        two_pulse(0, 1, 4);
        count_is(1, "R7 overlap 6 > 5");
        two_pulse(0, 1, 5);
        count_is(0, "R7 overlap 5 not > 5");
    endtask

    task automatic t_polarity();
        setup(2'd0, 4'b0010, 8'd10, 4'd0);
        edge_fall = 4'b0010;
        @(negedge clk); disc_in[1] = 1'b1;
        repeat (30) @(negedge clk);
        check(trig_cnt == 0, "R2 rising ignored when falling selected", trig_cnt, 0);
        disc_in[1] = 1'b0;
        count_is(1, "R2 falling edge fires");
        edge_fall = '0;
    endtask

    task automatic t_window();
        setup(2'd1, 4'b0011, 8'd8, 4'd0);
        two_pulse(0, 0, 6);
        repeat (5) @(negedge clk);
        disc_in[1] = 1'b1;
        @(negedge clk); disc_in[1] = 1'b0;
        count_is(1, "R3 restart extends window");
        setup(2'd0, 4'b1111, 8'd0, 4'd0);
        two_pulse(0, 1, 1);
        count_is(0, "R3 zero length opens nothing");
    endtask

    task automatic t_seam();
        setup(2'd0, 4'b0001, 8'd12, 4'd0);
        two_pulse(0, 0, 12);
        count_is(1, "R3 R8 reload on last cycle keeps window");
        two_pulse(0, 0, 13);
        count_is(2, "R8 gap releases hold-off");
        setup(2'd0, 4'b0011, 8'd20, 4'd0);
        two_pulse(0, 1, 5);
        count_is(1, "R8 held off while windows open");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latency();
        t_or_mask();
        t_and();
        t_pair();
        t_minw();
        t_polarity();
        t_window();
        t_seam();
        done = 1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", cyc, 0);
            report();
        end
    end
endmodule